// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block watches the destination address field of a frame arriving on the receive path, one byte per clock, with a byte position counter supplied by the framing logic (position 0 is the first byte after the start delimiter). While the six address bytes go by, it compares them against the programmed station address, recognises the all-ones broadcast address and runs a CRC-32 over them to index a 64-bit multicast hash filter.

One cycle after the sixth byte it presents a decision: accept or discard, plus three cause bits (station match, hash match, broadcast match) for the receive status word. A fixed precedence keeps at most one cause bit set, so software can tell which rule admitted the frame. Promiscuous mode admits everything. An external address detector, when enabled, admits frames by default and may veto them by strobing a reject line at any time before byte 64. The decision is held until the next frame starts.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: A frame whose first received byte has bit 0 clear is accepted with `match_phys` set when, with `cfg_no_ucast` low, received byte k (k = 0..5) equals `station_addr[8k+7:8k]` for all six bytes.
- R2: With `cfg_no_ucast` high, a frame equal to the station address is not accepted by the station rule and `match_phys` stays low.
- R3: A destination of six 0xFF bytes is accepted with `match_bcast` set when `cfg_no_bcast` is low; with `cfg_no_bcast` high the broadcast rule admits nothing and `match_bcast` stays low.
- R4: For a frame with bit 0 of the first byte set, a CRC-32 (polynomial 0x04C11DB7, register preset to all ones, each byte fed bit 0 first, register shifted toward bit 31, no final inversion) is run over the six bytes; bits [31:26] of the register index `hash_filter`; a set filter bit accepts the frame with `match_hash` set. A broadcast with `cfg_no_bcast` high is judged by this rule.
- R5: With `cfg_promisc` high every frame is accepted regardless of address, `cfg_no_ucast` and `cfg_no_bcast`; cause bits still report only the rules that matched on their own.
- R6: At most one cause bit is set at any time, and cause bits are low whenever `accept` is low; a broadcast with `cfg_no_bcast` low reports only `match_bcast` even when the hash filter would pass it.
- R7: With `cfg_ext_en` high a frame is accepted even if no internal rule matches, unless `ext_reject` is high during a cycle where `rx_valid` is high and `rx_pos` is below 64; such a reject drops `accept` and all cause bits from the next cycle until the next frame, overriding promiscuous mode. Rejects at position 64 or later, or with `cfg_ext_en` low, have no effect.
- R8: `decision_valid` rises in the cycle after the byte at position 5 is taken, stays high until a byte at position 0 is taken, and falls in the cycle after it; `accept` and cause bits are low while `decision_valid` is low.
- R9: After reset `decision_valid`, `accept` and all cause bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | A receive byte is present this cycle |
| rx_byte | input | 8 | Receive byte |
| rx_pos | input | 7 | Position of the byte after the start delimiter |
| station_addr | input | 48 | Station address, byte k in bits [8k+7:8k] |
| hash_filter | input | 64 | Multicast hash filter bits |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_no_bcast | input | 1 | Disable the broadcast rule |
| cfg_no_ucast | input | 1 | Disable the station address rule |
| cfg_ext_en | input | 1 | Enable the external detector |
| ext_reject | input | 1 | External reject strobe |
| decision_valid | output | 1 | Decision for the current frame is available |
| accept | output | 1 | Frame is accepted |
| match_phys | output | 1 | Accepted by station address match |
| match_hash | output | 1 | Accepted by hash filter |
| match_bcast | output | 1 | Accepted as broadcast |

## Verification
The assertions assume the framing logic numbers bytes strictly 0, 1, 2 and so on within a frame, so that position 5 is always preceded by position 0 of the same frame, and that the control inputs and filter stay constant while a decision is shown. The stimulus keeps to this by driving each frame as one unbroken run of positions starting at 0 and changing configuration only between frames, while the reference model follows every clock and also tracks the reject window across byte positions 63 and 64.

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter #(
  parameter int ADDR_BYTES    = 6,
  parameter int FILTER_BITS   = 64,
  parameter int REJECT_WINDOW = 64,
  parameter int POS_W         = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_byte,
  input  logic [POS_W-1:0]        rx_pos,
  input  logic [8*ADDR_BYTES-1:0] station_addr,
  input  logic [FILTER_BITS-1:0]  hash_filter,
  input  logic                    cfg_promisc,
  input  logic                    cfg_no_bcast,
  input  logic                    cfg_no_ucast,
  input  logic                    cfg_ext_en,
  input  logic                    ext_reject,
  output logic                    decision_valid,
  output logic                    accept,
  output logic                    match_phys,
  output logic                    match_hash,
  output logic                    match_bcast
);

  localparam int IDX_W = $clog2(FILTER_BITS);
  localparam logic [31:0] POLY = 32'h04C1_1DB7;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(ADDR_BYTES - 1);
  localparam logic [POS_W-1:0] ADDR_LIM = POS_W'(ADDR_BYTES);
  localparam logic [POS_W-1:0] WIN_LIM  = POS_W'(REJECT_WINDOW);

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[31] ^ b[i]) r = {r[30:0], 1'b0} ^ POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

  logic        addr_eq, all_ones, grp, rejected, done;
  logic [31:0] crc;
  logic [7:0]  sa_byte;

  wire first   = rx_valid && (rx_pos == '0);
  wire in_addr = rx_valid && (rx_pos < ADDR_LIM);
  wire rej_now = cfg_ext_en && ext_reject && rx_valid && (rx_pos < WIN_LIM);

  always_comb begin
    sa_byte = '0;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (rx_pos == POS_W'(i)) sa_byte = station_addr[8*i +: 8];
  end

  wire [31:0] crc_next = crc_step(first ? 32'hFFFF_FFFF : crc, rx_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_eq  <= 1'b0;
      all_ones <= 1'b0;
      grp      <= 1'b0;
      done     <= 1'b0;
      crc      <= '1;
    end else if (in_addr) begin
      addr_eq  <= (first || addr_eq) && (rx_byte == sa_byte);
      all_ones <= (first || all_ones) && (rx_byte == 8'hFF);
      grp      <= first ? rx_byte[0] : grp;
      crc      <= crc_next;
      done     <= (rx_pos == LAST_POS);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rejected <= 1'b0;
    else        rejected <= (rejected && !first) || rej_now;
  end

  wire [IDX_W-1:0] hash_idx = crc[31 -: IDX_W];
  wire hash_sel  = hash_filter[hash_idx];
  wire bcast_hit = all_ones && !cfg_no_bcast;
  wire phys_hit  = !grp && addr_eq && !cfg_no_ucast;
  wire hash_hit  = grp && hash_sel && !bcast_hit;
  wire pass      = done && !rejected;

  assign decision_valid = done;
  assign accept      = pass && (cfg_promisc || cfg_ext_en || phys_hit || bcast_hit || hash_hit);
  assign match_phys  = pass && phys_hit;
  assign match_hash  = pass && hash_hit;
  assign match_bcast = pass && bcast_hit;

  AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({match_phys, match_hash, match_bcast}) <= 1); // R6
  AST_CAUSE_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (match_phys || match_hash || match_bcast) |-> accept); // R6
  AST_BCAST_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_no_bcast |-> !match_bcast); // R3
  AST_UCAST_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_no_ucast |-> !match_phys); // R2
  AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (decision_valid && cfg_promisc && !cfg_ext_en) |-> accept); // R5
  AST_DECIDE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_pos == LAST_POS) |=> decision_valid); // R8
  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_pos == '0) |=> !decision_valid); // R8
  AST_QUIET_UNDECIDED: assert property (@(posedge clk) disable iff (!rst_n)
    !decision_valid |-> !accept); // R8
  AST_REJECT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ext_en && ext_reject && rx_valid && rx_pos != '0 && rx_pos < WIN_LIM) |=> !accept); // R7

endmodule

// File: tb/eth_rx_addr_filter_test.sv
module eth_rx_addr_filter_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        rx_valid = 0;
  logic [7:0]  rx_byte = 0;
  logic [6:0]  rx_pos = 0;
  logic [47:0] station_addr = 48'h665544332212;
  logic [63:0] hash_filter = 0;
  logic        cfg_promisc = 0, cfg_no_bcast = 0, cfg_no_ucast = 0, cfg_ext_en = 0;
  logic        ext_reject = 0;
  logic        decision_valid, accept, match_phys, match_hash, match_bcast;

  eth_rx_addr_filter uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_pos(rx_pos),
    .station_addr(station_addr), .hash_filter(hash_filter), .cfg_promisc(cfg_promisc),
    .cfg_no_bcast(cfg_no_bcast), .cfg_no_ucast(cfg_no_ucast), .cfg_ext_en(cfg_ext_en),
    .ext_reject(ext_reject), .decision_valid(decision_valid), .accept(accept),
    .match_phys(match_phys), .match_hash(match_hash), .match_bcast(match_bcast)
  );

  always #10 clk = ~clk;

  int    checks = 0, fails = 0, cycles = 0;
  string cur_tag = "R9";

  // reference model state
  logic [47:0] m_da = 0;
  logic        m_done = 0, m_rej = 0;

  function automatic int ref_idx(input logic [47:0] da);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int k = 0; k < 48; k++) begin
      logic fb;
      fb = c[31] ^ da[k];
      c = c << 1;
      if (fb) c = c ^ 32'h04C11DB7;
    end
    return int'(c >> 26);
  endfunction

  function automatic logic [4:0] ref_out();
    logic grp, ph, bc, hh, ok;
    grp = m_da[0];
    bc  = (m_da == 48'hFFFFFFFFFFFF) && !cfg_no_bcast;
    ph  = !grp && (m_da == station_addr) && !cfg_no_ucast;
    hh  = grp && hash_filter[ref_idx(m_da)] && !bc;
    ok  = m_done && !m_rej;
    return {m_done, ok && (cfg_promisc || cfg_ext_en || ph || bc || hh), ok && ph, ok && hh, ok && bc};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_done <= 0; m_rej <= 0;
    end else begin
      if (rx_valid && rx_pos < 6) begin
        m_da[8*rx_pos +: 8] <= rx_byte;
        m_done <= (rx_pos == 5);
      end
      if (rx_valid && rx_pos == 0) m_rej <= 0;
      if (cfg_ext_en && ext_reject && rx_valid && rx_pos < 64) m_rej <= 1;
    end
  end

  always @(negedge clk) begin
    logic [4:0] got, exp;
    got = {decision_valid, accept, match_phys, match_hash, match_bcast};
    exp = ref_out();
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: model compare got %b expected %b", cur_tag, got, exp);
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      report();
    end
  end

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic send(input logic [47:0] da, input int len, input int rej_at);
    for (int p = 0; p < len; p++) begin
      @(negedge clk); #2;
      rx_valid = 1; rx_pos = 7'(p);
      rx_byte = (p < 6) ? da[8*p +: 8] : 8'(p * 7);
      ext_reject = (p == rej_at);
    end
    @(negedge clk); #2;
    rx_valid = 0; ext_reject = 0;
    @(negedge clk);
  endtask

  task automatic expect4(input string tag, input logic a, input logic p, input logic h, input logic b);
    chk({tag, " accept"}, accept, a);
    chk({tag, " match_phys"}, match_phys, p);
    chk({tag, " match_hash"}, match_hash, h);
    chk({tag, " match_bcast"}, match_bcast, b);
  endtask

  initial begin
    logic [47:0] mc1, mc2;
    int i1;
    repeat (3) @(negedge clk);
    cur_tag = "R9";
    chk("R9 decision_valid", decision_valid, 0);
    expect4("R9", 0, 0, 0, 0);
    #2 rst_n = 1;

    cur_tag = "R1";
    send(station_addr, 10, -1);
    chk("R1 decision_valid", decision_valid, 1);
    expect4("R1", 1, 1, 0, 0);
    send(48'h122233445566, 10, -1);
    expect4("R1 byte order", 0, 0, 0, 0);

    cur_tag = "R2";
    cfg_no_ucast = 1;
    send(station_addr, 10, -1);
    expect4("R2", 0, 0, 0, 0);
    cfg_no_ucast = 0;

    cur_tag = "R3";
    send(48'hFFFFFFFFFFFF, 10, -1);
    expect4("R3", 1, 0, 0, 1);
    cfg_no_bcast = 1;
    send(48'hFFFFFFFFFFFF, 10, -1);
    expect4("R3 disabled", 0, 0, 0, 0);

    cur_tag = "R4";
    mc1 = 48'h0A00005E0001;
    i1 = ref_idx(mc1);
    mc2 = mc1;
    for (int k = 2; k < 40; k++) begin
      logic [47:0] c;
      c = {8'(k), 40'h00005E0001};
      if (ref_idx(c) != i1) begin mc2 = c; break; end
    end
    hash_filter = 64'd1 << i1;
    send(mc1, 10, -1);
    expect4("R4 hit", 1, 0, 1, 0);
    send(mc2, 10, -1);
    expect4("R4 miss", 0, 0, 0, 0);
    hash_filter = 0;
    send(mc1, 10, -1);
    expect4("R4 empty filter", 0, 0, 0, 0);
    hash_filter = '1;
    send(48'hFFFFFFFFFFFF, 10, -1);
    expect4("R4 bcast by hash", 1, 0, 1, 0);

    cur_tag = "R6";
    cfg_no_bcast = 0;
    send(48'hFFFFFFFFFFFF, 10, -1);
    expect4("R6 bcast precedence", 1, 0, 0, 1);
    hash_filter = 0;

    cur_tag = "R5";
    cfg_promisc = 1; cfg_no_ucast = 1; cfg_no_bcast = 1;
    send(48'h0123456789AA, 10, -1);
    expect4("R5 other unicast", 1, 0, 0, 0);
    send(station_addr, 10, -1);
    expect4("R5 own address", 1, 0, 0, 0);
    send(48'hFFFFFFFFFFFF, 10, -1);
    expect4("R5 bcast", 1, 0, 0, 0);
    send(mc2, 10, -1);
    expect4("R5 multicast", 1, 0, 0, 0);
    cfg_promisc = 0; cfg_no_ucast = 0; cfg_no_bcast = 0;

    cur_tag = "R7";
    send(48'h0123456789AA, 70, 40);
    expect4("R7 reject when disabled", 0, 0, 0, 0);
    cfg_ext_en = 1;
    send(48'h0123456789AA, 10, -1);
    expect4("R7 no reject", 1, 0, 0, 0);
    send(48'h0123456789AA, 70, 63);
    expect4("R7 reject at 63", 0, 0, 0, 0);
    send(48'h0123456789AA, 70, 64);
    expect4("R7 reject at 64", 1, 0, 0, 0);
    send(station_addr, 70, 2);
    expect4("R7 early reject", 0, 0, 0, 0);
    cfg_promisc = 1;
    send(48'hFFFFFFFFFFFF, 70, 30);
    expect4("R7 reject beats promisc", 0, 0, 0, 0);
    cfg_promisc = 0;
    send(station_addr, 10, -1);
    expect4("R7 reject cleared", 1, 1, 0, 0);
    cfg_ext_en = 0;

    cur_tag = "R8";
    for (int p = 0; p < 6; p++) begin
      @(negedge clk); #2;
      rx_valid = 1; rx_pos = 7'(p); rx_byte = station_addr[8*p +: 8];
      @(negedge clk);
      chk($sformatf("R8 decision_valid after byte %0d", p), decision_valid, p == 5);
      #2 rx_valid = 0;
    end
    repeat (3) @(negedge clk);
    chk("R8 decision held", decision_valid, 1);
    expect4("R8 held", 1, 1, 0, 0);

    repeat (2) @(negedge clk);
    report();
  end
endmodule